// File: doc/BRIEF.md
# Bus Cycle End and Ready Generator

This block decides when a CPU bus command cycle may finish. It decodes the type of the current bus command (memory access, I/O write, I/O read), the request for zero wait states and the two 16-bit sizing indications into an active-low end-of-cycle signal. It also keeps a short shift timer whose taps give later points at which a cycle may end. All state advances on the falling edge of a clock that runs at twice the CPU rate.

A command-start strobe arms the timer for cycles that do not ask for zero wait states. A single one then walks through the taps Q1 to Q4, one tap per double-clock period, and the timer returns to all zeros. The first tap lets 16-bit I/O and 16-bit memory cycles end early. The last tap ends any cycle that is still running. The registered ready output follows end-of-cycle by one falling edge, and the CPU leaves the command phase on it.

Top module: `bus_cycle_end`

## Requirements
- R1: While `rst` is high at a falling edge of `clk2x`, the block holds `end_cyc_n` at 1, `ready_n` at 1 and `tap_q` at all zeros. This holds even when a decode term is true.
- R2: When `mem_acc`=1 or `io_wr`=1 while `zero_wait_n`=0, `end_cyc_n` goes to 0 in the same cycle, combinationally, without any timer tap.
- R3: While the last tap (`tap_q[3]`, Q4) is 1, `end_cyc_n` is 0 whatever the bus inputs are.
- R4: While the first tap (`tap_q[0]`, Q1) is 1 and `io16_n`=0, `end_cyc_n` is 0 if `io_rd_n`=0 or `io_wr`=1. With `io16_n`=1 and no other term true, it stays 1.
- R5: While Q1 is 1, `mem_acc`=1 and `mem16`=1 together drive `end_cyc_n` to 0. With `mem16`=0 and no other term true, it stays 1.
- R6: When no term is true, `end_cyc_n` stays 1. With no command start, `tap_q` stays all zeros.
- R7: When `cmd_start`=1 at a falling edge while the timer is idle, the timer arms. Q1 is 1 after the next falling edge, and the one moves up by one tap per falling edge to Q4. The falling edge after Q4 leaves `tap_q` at all zeros.
- R8: A `cmd_start` sampled while a zero-wait term of R2 is true does not arm the timer.
- R9: A `cmd_start` sampled while the timer is armed or any tap is 1 is ignored. The running pulse is neither restarted nor followed by a second one.
- R10: At each falling edge, `ready_n` takes the value of `end_cyc_n`. Its idle value is 1.
- R11: At most one tap of `tap_q` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_acc | input | 1 | Memory access in progress |
| io_wr | input | 1 | I/O write in progress |
| io_rd_n | input | 1 | I/O read, active low |
| io16_n | input | 1 | 16-bit I/O target selected, active low |
| zero_wait_n | input | 1 | Zero-wait-state request, active low |
| mem16 | input | 1 | 16-bit memory target |
| cmd_start | input | 1 | Command-start strobe that arms the timer |
| end_cyc_n | output | 1 | End of bus cycle, active low |
| ready_n | output | 1 | Registered ready to the CPU, active low |
| tap_q | output | TAPS | Timer taps, bit 0 = Q1, top bit = Q4 |

## Verification
The Q1-gated terms are the hardest to reach. They can only be seen during the single double-clock period in which Q1 is high. Each bus input pattern must also be applied without any zero-wait term, because such a term would both mask the result and block the timer from arming. For this reason each scenario sets its bus inputs before pulsing the start strobe, then checks end-of-cycle one period before Q1, at Q1, after Q1 and again at Q4. This separates the term under test from the Q4 term that always follows. Restarting a running pulse is checked by pulsing the strobe mid-sequence and watching the taps stay at zero after Q4.

// File: rtl/bce_pkg.sv
package bce_pkg;

    // Bus command inputs, as sampled by the end-of-cycle decode
    typedef struct packed {
        logic mem_acc;
        logic io_wr;
        logic io_rd_n;
        logic io16_n;
        logic zero_wait_n;
        logic mem16;
    } bus_cmd_t;

    localparam int TERM_COUNT = 6;

    // Term slots in the decode vector
    localparam int TERM_LAST_TAP = 0;
    localparam int TERM_MEM_ZWS  = 1;
    localparam int TERM_IOW_ZWS  = 2;
    localparam int TERM_IOR_16   = 3;
    localparam int TERM_IOW_16   = 4;
    localparam int TERM_MEM_16   = 5;

endpackage

// File: rtl/bce_end_decode.sv
module bce_end_decode
    import bce_pkg::*;
(
    input  bus_cmd_t cmd,
    input  logic     first_tap,
    input  logic     last_tap,
    output logic     end_hit,
    output logic     zws_hit
);

    logic [TERM_COUNT-1:0] term;

    always_comb begin
        term                = '0;
        term[TERM_LAST_TAP] = last_tap;
        term[TERM_MEM_ZWS]  = cmd.mem_acc & ~cmd.zero_wait_n;
        term[TERM_IOW_ZWS]  = cmd.io_wr   & ~cmd.zero_wait_n;
        term[TERM_IOR_16]   = ~cmd.io_rd_n & first_tap & ~cmd.io16_n;
        term[TERM_IOW_16]   = cmd.io_wr    & first_tap & ~cmd.io16_n;
        term[TERM_MEM_16]   = cmd.mem_acc  & first_tap & cmd.mem16;
        end_hit = |term;
        zws_hit = term[TERM_MEM_ZWS] | term[TERM_IOW_ZWS];
    end

endmodule

// File: rtl/bce_cycle_timer.sv
module bce_cycle_timer #(
    parameter int TAPS = 4
) (
    input  logic            clk2x,
    input  logic            rst,
    input  logic            start,
    input  logic            hold_off,
    output logic [TAPS-1:0] taps
);

    typedef struct packed {
        logic            armed;
        logic [TAPS-1:0] taps;
    } tmr_t;

    tmr_t st_d, st_q;
    logic idle;

    always_comb begin
        idle        = !st_q.armed && (st_q.taps == '0);
        st_d        = st_q;
        st_d.taps   = {st_q.taps[TAPS-2:0], st_q.armed};
        st_d.armed  = idle && start && !hold_off;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(negedge clk2x) begin
        st_q <= st_d;
    end

    assign taps = st_q.taps;

    // R11
    onehot_taps_chk: assert property (@(negedge clk2x) disable iff (rst)
        $onehot0({st_q.armed, st_q.taps}));

    // R7
    arm_to_first_chk: assert property (@(negedge clk2x) disable iff (rst)
        st_q.armed |=> (st_q.taps[0] && !st_q.armed));

    // R7
    last_clears_chk: assert property (@(negedge clk2x) disable iff (rst)
        st_q.taps[TAPS-1] |=> (st_q.taps == '0 && !st_q.armed));

    // R6
    idle_hold_chk: assert property (@(negedge clk2x) disable iff (rst)
        (idle && !start) |=> (st_q.taps == '0 && !st_q.armed));

    // R9
    busy_ignore_chk: assert property (@(negedge clk2x) disable iff (rst)
        (st_q.taps[0] && start) |=> (st_q.taps[1] && !st_q.armed));

endmodule

// File: rtl/bus_cycle_end.sv
module bus_cycle_end
    import bce_pkg::*;
#(
    parameter int TAPS = 4
) (
    input  logic            clk2x,
    input  logic            rst,
    input  logic            mem_acc,
    input  logic            io_wr,
    input  logic            io_rd_n,
    input  logic            io16_n,
    input  logic            zero_wait_n,
    input  logic            mem16,
    input  logic            cmd_start,
    output logic            end_cyc_n,
    output logic            ready_n,
    output logic [TAPS-1:0] tap_q
);

    localparam int LAST = TAPS - 1;

    typedef struct packed {
        logic ready_n;
    } top_t;

    bus_cmd_t cmd;
    logic     end_hit;
    logic     zws_hit;
    top_t     st_d, st_q;

    assign cmd = '{mem_acc: mem_acc, io_wr: io_wr, io_rd_n: io_rd_n,
                   io16_n: io16_n, zero_wait_n: zero_wait_n, mem16: mem16};

    bce_end_decode u_decode (
        .cmd       (cmd),
        .first_tap (tap_q[0]),
        .last_tap  (tap_q[LAST]),
        .end_hit   (end_hit),
        .zws_hit   (zws_hit)
    );

    bce_cycle_timer #(.TAPS(TAPS)) u_timer (
        .clk2x    (clk2x),
        .rst      (rst),
        .start    (cmd_start),
        .hold_off (zws_hit),
        .taps     (tap_q)
    );

    assign end_cyc_n = rst | ~end_hit;

    always_comb begin
        st_d         = st_q;
        st_d.ready_n = end_cyc_n;
        if (rst) begin
            st_d.ready_n = 1'b1;
        end
    end

    always_ff @(negedge clk2x) begin
        st_q <= st_d;
    end

    assign ready_n = st_q.ready_n;

    // R2
    zws_ready_chk: assert property (@(negedge clk2x) disable iff (rst)
        ((mem_acc || io_wr) && !zero_wait_n) |=> !ready_n);

    // R3
    last_tap_ready_chk: assert property (@(negedge clk2x) disable iff (rst)
        tap_q[LAST] |=> !ready_n);

    // R8
    zws_no_arm_chk: assert property (@(negedge clk2x) disable iff (rst)
        (tap_q == '0 && (mem_acc || io_wr) && !zero_wait_n) |=> ##1 (tap_q == '0));

endmodule

// File: tb/bus_cycle_end_test.sv
module bus_cycle_end_test;

    localparam int TAPS = 4;

    logic            clk2x = 1'b0;
    logic            rst = 1'b1;
    logic            mem_acc = 1'b0;
    logic            io_wr = 1'b0;
    logic            io_rd_n = 1'b1;
    logic            io16_n = 1'b1;
    logic            zero_wait_n = 1'b1;
    logic            mem16 = 1'b0;
    logic            cmd_start = 1'b0;
    logic            end_cyc_n;
    logic            ready_n;
    logic [TAPS-1:0] tap_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk2x = ~clk2x;

    bus_cycle_end #(.TAPS(TAPS)) uut (
        .clk2x(clk2x), .rst(rst), .mem_acc(mem_acc), .io_wr(io_wr),
        .io_rd_n(io_rd_n), .io16_n(io16_n), .zero_wait_n(zero_wait_n),
        .mem16(mem16), .cmd_start(cmd_start), .end_cyc_n(end_cyc_n),
        .ready_n(ready_n), .tap_q(tap_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk2x);
        #1;
    endtask

    task automatic idle_inputs();
        mem_acc = 0; io_wr = 0; io_rd_n = 1; io16_n = 1;
        zero_wait_n = 1; mem16 = 0; cmd_start = 0;
        #1;
    endtask

    // after this the timer is armed, taps still zero
    task automatic start_cycle();
        cmd_start = 1;
        tick();
        cmd_start = 0;
        #1;
    endtask

    task automatic settle_idle();
        idle_inputs();
        for (int i = 0; i < 7; i++) tick();
    endtask

    task automatic test_reset();
        mem_acc = 1; zero_wait_n = 0; rst = 1;
        tick(); tick();
        chk("R1 end_cyc_n in reset", end_cyc_n, 1);
        chk("R1 ready_n in reset", ready_n, 1);
        chk("R1 taps in reset", tap_q, 0);
        idle_inputs();
        rst = 0;
        tick();
        start_cycle();
        tick();
        rst = 1;
        tick();
        chk("R1 reset clears running taps", tap_q, 0);
        tick();
        chk("R1 taps stay cleared", tap_q, 0);
        rst = 0;
        tick();
    endtask

    task automatic test_idle();
        idle_inputs();
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R6 idle end_cyc_n", end_cyc_n, 1);
            chk("R6 idle taps", tap_q, 0);
        end
        chk("R10 idle ready_n", ready_n, 1);
    endtask

    task automatic test_zws(input bit use_write);
        idle_inputs();
        tick();
        if (use_write) io_wr = 1; else mem_acc = 1;
        zero_wait_n = 0;
        #1;
        chk("R2 zero-wait end same cycle", end_cyc_n, 0);
        tick();
        chk("R10 ready_n follows end", ready_n, 0);
        start_cycle();
        for (int i = 0; i < 5; i++) begin
            chk("R8 start blocked by zero-wait", tap_q, 0);
            tick();
        end
        idle_inputs();
        chk("R2 end released", end_cyc_n, 1);
        tick();
        chk("R10 ready_n back high", ready_n, 1);
    endtask

    task automatic test_last_tap();
        idle_inputs();
        tick();
        start_cycle();
        chk("R7 armed taps zero", tap_q, 0);
        chk("R6 no end before Q1", end_cyc_n, 1);
        tick();
        chk("R7 Q1", tap_q, 1);
        chk("R6 Q1 alone no end", end_cyc_n, 1);
        tick();
        chk("R7 Q2", tap_q, 2);
        tick();
        chk("R7 Q3", tap_q, 4);
        chk("R6 Q3 no end", end_cyc_n, 1);
        tick();
        chk("R7 Q4", tap_q, 8);
        chk("R3 Q4 ends cycle", end_cyc_n, 0);
        tick();
        chk("R7 taps back to zero", tap_q, 0);
        chk("R3 end released", end_cyc_n, 1);
        chk("R10 ready_n after Q4", ready_n, 0);
        tick();
        chk("R10 ready_n released", ready_n, 1);
        chk("R7 taps stay zero", tap_q, 0);
    endtask

    // term under test set up by caller; expect_q1 = end_cyc_n expected at Q1
    task automatic run_q1_term(input string req, input int expect_q1);
        tick();
        start_cycle();
        chk({req, " before Q1"}, end_cyc_n, 1);
        tick();
        chk({req, " at Q1"}, end_cyc_n, expect_q1);
        tick();
        chk({req, " after Q1"}, end_cyc_n, 1);
        tick(); tick();
        chk("R3 Q4 still ends", end_cyc_n, 0);
        settle_idle();
    endtask

    task automatic test_io_read16();
        idle_inputs();
        io_rd_n = 0; io16_n = 0;
        run_q1_term("R4 io read 16", 0);
        io_rd_n = 0; io16_n = 1;
        run_q1_term("R4 io read 8 no end", 1);
    endtask

    task automatic test_io_write16();
        idle_inputs();
        io_wr = 1; io16_n = 0;
        run_q1_term("R4 io write 16", 0);
        io_wr = 1; io16_n = 1;
        run_q1_term("R4 io write 8 no end", 1);
    endtask

    task automatic test_mem16();
        idle_inputs();
        mem_acc = 1; mem16 = 1;
        run_q1_term("R5 mem 16", 0);
        mem_acc = 1; mem16 = 0;
        run_q1_term("R5 mem 8 no end", 1);
    endtask

    task automatic test_restart_ignored();
        idle_inputs();
        tick();
        start_cycle();
        tick();
        chk("R9 Q1 reached", tap_q, 1);
        cmd_start = 1;
        tick();
        cmd_start = 0;
        chk("R9 shift continues", tap_q, 2);
        tick(); tick();
        chk("R9 Q4 on time", tap_q, 8);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R9 no second pulse", tap_q, 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_idle();
        test_zws(1'b0);
        test_zws(1'b1);
        test_last_tap();
        test_io_read16();
        test_io_write16();
        test_mem16();
        test_restart_ignored();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule